// File: doc/BRIEF.md
# Programmable Interrupt Request Gateway Bank

This block conditions a set of raw external interrupt lines before they reach a priority arbiter. Every source has its own gateway. The gateway applies a programmable polarity and a programmable trigger type, then drives one bit of a pending vector. Source 0 is reserved and never pends. Software configures the gateways through a word-addressed register port that uses single-cycle read and write strobes. Each source has a control word and a clear word, and one read-only word shows the whole pending vector.

Each gateway is a two-state machine with the states `GW_IDLE` and `GW_PEND`. In level mode the machine is held in `GW_IDLE` (transition `LEVEL_FLUSH` from `GW_PEND`), and the pending output follows the polarity-adjusted input with no register in the path. In edge mode the transition `ARM` (from `GW_IDLE` to `GW_PEND`) is taken on any cycle where the adjusted input is active. The transition `CLEAR` (from `GW_PEND` to `GW_IDLE`) is taken only on a clear write in a cycle where the adjusted input is inactive. There is no edge detector. An input that stays active therefore keeps the source pending even after a clear. Unused inputs must be tied to their inactive level: 0 when programmed active-high, 1 when programmed active-low.

Address map (byte addresses, 32-bit words): the control word for source n is at `0x000 + 4n`, the clear word for source n is at `0x100 + 4n`, and the pending vector is at `0x200`, where bit n reports source n.

Top module: `irqgw_bank`

## Requirements
- R1: After reset every control word is 0, which selects active-high polarity and level mode. With all inputs low, no source is pending.
- R2: Control bit 0 selects polarity. A value of 1 makes a low input the active level, and a value of 0 makes a high input the active level.
- R3: With control bit 1 at 0 (level mode), `pend_out[n]` equals the polarity-adjusted input in the same cycle, with no register in the path.
- R4: With control bit 1 at 1 (edge mode), an active adjusted input sets the source's latch. The latch shows on `pend_out` in the next cycle and stays set after the input goes inactive.
- R5: A write of any value to the clear word of source n empties that source's latch from the next cycle, provided the adjusted input is inactive in the cycle of the write. Only source n is affected.
- R6: In edge mode, an adjusted input that is active in the same cycle as a clear write keeps the latch set. A stuck-active input therefore stays pending.
- R7: The pending word at `0x200` is read-only. A write to it changes no pending bit and no control word.
- R8: Source 0 is reserved. `pend_out[0]` is always 0, and its control word reads as 0 and ignores writes.
- R9: Reads from the clear region return 0. Unmapped or unaligned addresses read as 0 and ignore writes. `reg_rdata` is 0 when `reg_rd` is low.
- R10: A read of a control word returns the polarity in bit 0 and the trigger type in bit 1, with bits 31:2 at 0. Read data is combinational in the strobe cycle and shows the value from before any write in the same cycle.
- R11: While a source is in level mode its latch is held empty. Switching the source back to edge mode with an inactive input leaves it not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gateway clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_raw | input | NSRC-1 | Raw request lines for sources 1 to NSRC-1, already synchronous to `clk` |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| pend_out | output | NSRC | Pending requests toward the arbiter; bit 0 is always 0 |

## Verification
The assertions check on every cycle that an edge-mode latch, once set, stays set until a clear write arrives while the input is inactive. They also check that such a clear actually empties the latch, that a clear does not win over an active input, and that a write outside the control region leaves every control word untouched. The same-cycle level pass-through, polarity inversion, read-back layout, the reserved source 0 and the behaviour of unmapped and clear-region reads can only be shown by the bench. It drives these behaviours through the ports and compares every pending bit and every read against its own model, under directed corner cases and random traffic.

// File: rtl/irqgw_pkg.sv
package irqgw_pkg;

    // Per-source gateway state
    typedef enum logic {
        GW_IDLE = 1'b0,
        GW_PEND = 1'b1
    } gw_state_e;

    // Control word layout: bit 1 trigger type, bit 0 polarity
    typedef struct packed {
        logic trig_edge;   // 1: edge-latched, 0: level pass-through
        logic pol_low;     // 1: active-low, 0: active-high
    } gw_ctrl_t;

    // Register region decoded from an address
    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_CLR  = 2'd1,
        RG_PEND = 2'd2,
        RG_NONE = 2'd3
    } rg_region_e;

endpackage

// File: rtl/irqgw_cell.sv
module irqgw_cell
    import irqgw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     raw,
    input  gw_ctrl_t ctrl,
    input  logic     clr,
    output logic     pend
);

    gw_state_e state_q;
    gw_state_e state_d;
    logic      active;

    // polarity-adjusted request
    assign active = raw ^ ctrl.pol_low;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: begin
                if (ctrl.trig_edge && active) begin
                    state_d = GW_PEND;              // ARM
                end
            end
            GW_PEND: begin
                if (!ctrl.trig_edge) begin
                    state_d = GW_IDLE;              // LEVEL_FLUSH
                end else if (clr && !active) begin
                    state_d = GW_IDLE;              // CLEAR (set wins)
                end
            end
            default: state_d = GW_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        if (ctrl.trig_edge) begin
            pend = (state_q == GW_PEND);
        end else begin
            pend = active;
        end
    end

    // R4: a latched request stays latched without a clear
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.trig_edge && pend && !clr) |=> (!ctrl.trig_edge || pend));

    // R6: an active input in edge mode always leaves the latch set
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.trig_edge && active) |=> (!ctrl.trig_edge || pend));

    // R5: a clear with an inactive input empties the latch
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.trig_edge && clr && !active) |=> (!ctrl.trig_edge || !pend));

endmodule

// File: rtl/irqgw_regs.sv
module irqgw_regs
    import irqgw_pkg::*;
#(
    parameter int          NSRC      = 32,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] CTRL_BASE = 32'h000,
    parameter logic [31:0] CLR_BASE  = 32'h100,
    parameter logic [31:0] PEND_ADDR = 32'h200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    input  logic [NSRC-1:0]         pend_vec,
    output gw_ctrl_t [NSRC-1:1]     ctrl_vec,
    output logic     [NSRC-1:1]     clr_vec,
    output logic [DATA_W-1:0]       reg_rdata
);

    localparam int              IDX_W   = $clog2(NSRC);
    localparam int              SPAN    = NSRC * 4;
    localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(SPAN);
    localparam logic [ADDR_W-1:0] CTRL_LO = CTRL_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CLR_LO  = CLR_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PEND_A  = PEND_ADDR[ADDR_W-1:0];

    logic [ADDR_W-1:0] off_ctrl;
    logic [ADDR_W-1:0] off_clr;
    logic [IDX_W-1:0]  idx;
    rg_region_e        region;
    gw_ctrl_t [NSRC-1:1] ctrl_q;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:2];

    assign off_ctrl = reg_addr - CTRL_LO;
    assign off_clr  = reg_addr - CLR_LO;

    // region decode
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (reg_addr[1:0] == 2'b00) begin
            if (off_ctrl < SPAN_A) begin
                region = RG_CTRL;
                idx    = off_ctrl[IDX_W+1:2];
            end else if (off_clr < SPAN_A) begin
                region = RG_CLR;
                idx    = off_clr[IDX_W+1:2];
            end else if (reg_addr == PEND_A) begin
                region = RG_PEND;
            end
        end
    end

    // per-source control and clear strobes
    for (genvar i = 1; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[i] <= '0;
            end else if (reg_wr && (region == RG_CTRL) && (idx == IDX_W'(i))) begin
                ctrl_q[i] <= gw_ctrl_t'(reg_wdata[1:0]);
            end
        end
        assign clr_vec[i] = reg_wr && (region == RG_CLR) && (idx == IDX_W'(i));
    end

    assign ctrl_vec = ctrl_q;

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (region)
                RG_CTRL: begin
                    if (idx != '0) begin
                        reg_rdata[1:0] = ctrl_q[idx];
                    end
                end
                RG_PEND: reg_rdata[NSRC-1:0] = pend_vec;
                RG_CLR:  reg_rdata = '0;
                RG_NONE: reg_rdata = '0;
                default: reg_rdata = '0;
            endcase
        end
    end

    // R7: writes outside the control region leave every control word alone
    p_ctrl_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (region != RG_CTRL)) |=> $stable(ctrl_q));

endmodule

// File: rtl/irqgw_bank.sv
module irqgw_bank
    import irqgw_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:1]   irq_raw,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NSRC-1:0]   pend_out
);

    gw_ctrl_t [NSRC-1:1] ctrl_vec;
    logic     [NSRC-1:1] clr_vec;
    logic     [NSRC-1:0] pend_w;

    irqgw_regs #(
        .NSRC   (NSRC),
        .ADDR_W (ADDR_W),
        .DATA_W (32)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_vec  (pend_w),
        .ctrl_vec  (ctrl_vec),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

    // source 0 is reserved and never pends
    assign pend_w[0] = 1'b0;

    for (genvar i = 1; i < NSRC; i++) begin : g_gw
        irqgw_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (irq_raw[i]),
            .ctrl  (ctrl_vec[i]),
            .clr   (clr_vec[i]),
            .pend  (pend_w[i])
        );
    end

    assign pend_out = pend_w;

endmodule

// File: tb/irqgw_bank_tb_top.sv
module irqgw_bank_tb_top;

    localparam int NSRC = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NSRC-1:1]   irq_raw;
    logic              reg_wr;
    logic              reg_rd;
    logic [11:0]       reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic [NSRC-1:0]   pend_out;

    int checks = 0;
    int errors = 0;

    bit m_pol [NSRC];
    bit m_typ [NSRC];
    bit m_lat [NSRC];

    always #10 clk = ~clk;

    irqgw_bank #(.NSRC(NSRC), .ADDR_W(12)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_raw   (irq_raw),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pend_out  (pend_out)
    );

    function automatic logic [11:0] ctrl_a(int id);
        return 12'(id * 4);
    endfunction

    function automatic logic [11:0] clr_a(int id);
        return 12'(32'h100 + id * 4);
    endfunction

    function automatic logic [NSRC-1:0] exp_pend(logic [NSRC-1:1] raw);
        logic [NSRC-1:0] v = '0;
        for (int i = 1; i < NSRC; i++) begin
            v[i] = m_typ[i] ? m_lat[i] : (raw[i] ^ m_pol[i]);
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a, logic [NSRC-1:1] raw);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a < 12'h080) begin
            int id = int'(a >> 2);
            if (id == 0) return 32'h0;
            return {30'h0, m_typ[id], m_pol[id]};
        end
        if (a == 12'h200) return 32'(exp_pend(raw));
        return 32'h0;
    endfunction

    task automatic cyc(input logic [NSRC-1:1] raw, input bit wr, input bit rd,
                       input logic [11:0] a, input logic [31:0] d, input string tag);
        logic [NSRC-1:0] ep;
        logic [31:0]     er;
        @(negedge clk);
        irq_raw   = raw;
        reg_wr    = wr;
        reg_rd    = rd;
        reg_addr  = a;
        reg_wdata = d;
        #1;
        ep = exp_pend(raw);
        checks++;
        if (pend_out !== ep) begin
            errors++;
            $display("FAIL %s pend_out actual=%h expected=%h", tag, pend_out, ep);
        end
        if (rd) begin
            er = exp_rd(a, raw);
            checks++;
            if (reg_rdata !== er) begin
                errors++;
                $display("FAIL %s rdata @%h actual=%h expected=%h", tag, a, reg_rdata, er);
            end
        end else begin
            checks++;
            if (reg_rdata !== 32'h0) begin
                errors++;
                $display("FAIL R9 idle rdata actual=%h expected=0", reg_rdata);
            end
        end
        @(posedge clk);
        if (rst_n) begin
            for (int i = 1; i < NSRC; i++) begin
                bit act = raw[i] ^ m_pol[i];
                bit clr = wr && (a == clr_a(i));
                if (!m_typ[i])      m_lat[i] = 1'b0;
                else if (act)       m_lat[i] = 1'b1;
                else if (clr)       m_lat[i] = 1'b0;
            end
            if (wr && a[1:0] == 2'b00 && a < 12'h080 && a != 12'h000) begin
                m_pol[int'(a >> 2)] = d[0];
                m_typ[int'(a >> 2)] = d[1];
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NSRC-1:1] r;
        logic [NSRC-1:1] b5;
        void'($urandom(32'd1234));
        b5 = '0;
        b5[5] = 1'b1;
        rst_n = 1'b0;
        irq_raw = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        for (int i = 0; i < NSRC; i++) begin
            m_pol[i] = 0; m_typ[i] = 0; m_lat[i] = 0;
        end
        cyc('0, 0, 0, 12'h0, 0, "R1 in reset");
        cyc('0, 0, 0, 12'h0, 0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc('0, 0, 1, ctrl_a(5), 0, "R1 ctrl after reset");
        cyc('0, 0, 1, 12'h200, 0, "R1 pend after reset");
        // R3: level pass-through, same cycle
        cyc(b5, 0, 1, 12'h200, 0, "R3 level high");
        cyc('0, 0, 0, 12'h0, 0, "R3 level drop");
        // R2: active-low polarity
        cyc('0, 1, 0, ctrl_a(5), 32'h1, "R2 set active-low");
        cyc('0, 0, 0, 12'h0, 0, "R2 low input pends");
        cyc(b5, 0, 0, 12'h0, 0, "R2 high input idle");
        // R4: edge mode latch
        cyc('0, 1, 0, ctrl_a(5), 32'h2, "R4 set edge high");
        cyc(b5, 0, 0, 12'h0, 0, "R4 pulse");
        cyc('0, 0, 0, 12'h0, 0, "R4 latched");
        cyc('0, 0, 1, 12'h200, 0, "R4 still latched");
        // R5: clear with inactive input
        cyc('0, 1, 0, clr_a(5), 32'hDEAD_BEEF, "R5 clear write");
        cyc('0, 0, 1, 12'h200, 0, "R5 cleared");
        // R6: stuck-active input survives a clear
        cyc(b5, 0, 0, 12'h0, 0, "R6 arm");
        cyc(b5, 1, 0, clr_a(5), 32'h0, "R6 clear while active");
        cyc(b5, 0, 0, 12'h0, 0, "R6 still pending");
        cyc('0, 1, 0, clr_a(5), 32'h0, "R6 release then clear");
        cyc('0, 0, 0, 12'h0, 0, "R6 cleared");
        // R7: pending word is read-only
        cyc(b5, 0, 0, 12'h0, 0, "R7 arm");
        cyc('0, 1, 0, 12'h200, 32'h0, "R7 write pend word");
        cyc('0, 1, 1, 12'h200, 32'hFFFF_FFFF, "R7 write pend ones");
        cyc('0, 0, 1, ctrl_a(5), 0, "R7 ctrl intact");
        cyc('0, 1, 0, clr_a(5), 0, "R7 cleanup");
        // R8: reserved source 0
        cyc('1, 1, 0, ctrl_a(0), 32'h3, "R8 write ctrl0");
        cyc('0, 0, 1, ctrl_a(0), 0, "R8 ctrl0 reads zero");
        cyc('0, 0, 1, 12'h200, 0, "R8 pend bit0 zero");
        // R9: clear region and unmapped reads, unmapped writes
        cyc('0, 0, 1, clr_a(7), 0, "R9 clear region read");
        cyc('0, 1, 1, 12'h300, 32'h3, "R9 unmapped write");
        cyc('0, 1, 1, 12'h015, 32'h3, "R9 unaligned write");
        cyc('0, 0, 1, ctrl_a(5), 0, "R9 ctrl unchanged");
        // R10: control read-back layout and read-before-write
        cyc('0, 1, 0, ctrl_a(7), 32'hFFFF_FFFF, "R10 write all ones");
        cyc('0, 0, 1, ctrl_a(7), 0, "R10 read back");
        cyc('0, 1, 1, ctrl_a(7), 32'h0, "R10 read during write");
        cyc('0, 0, 1, ctrl_a(7), 0, "R10 after write");
        // R11: level mode flushes latch
        cyc(b5, 0, 0, 12'h0, 0, "R11 arm");
        cyc('0, 1, 0, ctrl_a(5), 32'h0, "R11 to level");
        cyc('0, 1, 0, ctrl_a(5), 32'h2, "R11 back to edge");
        cyc('0, 0, 1, 12'h200, 0, "R11 not pending");
        // random mix
        r = '0;
        for (int n = 0; n < 3000; n++) begin
            int op = int'($urandom % 6);
            int id = int'($urandom % NSRC);
            if (($urandom % 4) == 0) r = NSRC'($urandom) >> 1;
            unique case (op)
                0: cyc(r, 1, 0, ctrl_a(id), $urandom, "R2 R3 R4 random ctrl");
                1: cyc(r, 1, 0, clr_a(id), $urandom, "R5 R6 random clear");
                2: cyc(r, 1, 1, 12'h200, $urandom, "R7 random pend write");
                3: cyc(r, 0, 1, 12'($urandom % 12'h400), 0, "R9 R10 random read");
                default: cyc(r, 0, 1, 12'h200, 0, "R3 R4 random idle");
            endcase
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule